// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter inside a small 4-bit controller. Software sets up three short control registers through a 4-bit write path. One register holds the input channel and the operating mode, one holds the analog pin enables, and one selects the conversion clock divider. A start pulse then launches a conversion. The sequencer spends two instruction ticks in a setup phase. It then resolves the ten result bits, most significant first, over ten periods of the divided conversion clock. For each bit it drives a trial code to the external DAC and reads a single comparator bit back.

When the last bit is resolved, the result is copied into a holding register and a completion flag rises. Software polls that flag as a skip condition. The result is read out as nibbles: the upper eight bits appear as a high nibble and a middle nibble, and the two lowest bits appear in the top two positions of a third nibble. The analog DAC, the comparator and any interrupt logic sit outside the block. The instruction tick `inst_tick_i` is a clock enable that paces all timing.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset (`rst_ni` low), the following outputs are all 0: `done_o`, `busy_o`, `dac_code_o`, `ch_sel_o`, `mode_o`, `ana_en_o`, `rd_hi_o`, `rd_mid_o` and `rd_lo_o`. The divider code is also 0.
- R2: A write with `cfg_we_i` high stores `cfg_wdata_i` in the register chosen by `cfg_sel_i`:
  - Code 0 is the channel/mode register. Bits 1:0 appear on `ch_sel_o`, and bit 3 appears on `mode_o`.
  - Code 1 is the pin-function register. It appears on `ana_en_o`, and bit 0 enables analog input 0.
  - Code 2 stores bits 2:0 as the divider code.
- R3: A `start_i` pulse with `mode_o` = 0 (conversion mode) clears `done_o` and raises `busy_o` on the next cycle. A start while `mode_o` = 1 is ignored.
- R4: `done_o` rises on the edge that carries the (2 + 10·D)-th instruction tick after the start edge. D = 6 << code[1:0], so code 0 gives the instruction clock divided by 6. Bit 2 of the code has no effect. Cycles without `inst_tick_i` do not advance the sequence.
- R5: During the setup phase `dac_code_o` is 0. In each step it carries the bits resolved so far with the current trial bit set, starting from 10'h200. At the end of the step's period, the trial bit is kept if `cmp_i` is 1 and cleared if it is 0. With an ideal comparator, the result equals the input level.
- R6: `rd_hi_o` is result[9:6] and `rd_mid_o` is result[5:2]. `rd_lo_o` holds result[1:0] in its bits 3:2, with zeros in bits 1:0.
- R7: The result outputs keep their value until the next conversion completes. `done_o` stays set until the next accepted start.
- R8: A start accepted while a conversion is running restarts it from the setup phase. The full conversion time then counts from the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inst_tick_i | input | 1 | Instruction-clock enable |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_sel_i | input | 2 | Control register select |
| cfg_wdata_i | input | 4 | Control register write data |
| start_i | input | 1 | Conversion start pulse |
| cmp_i | input | 1 | Comparator: input at or above DAC level |
| dac_code_o | output | 10 | Trial code to the DAC |
| busy_o | output | 1 | Conversion in progress (DAC active) |
| done_o | output | 1 | Completion flag |
| ch_sel_o | output | 2 | Selected input channel |
| mode_o | output | 1 | Mode bit, 0 = conversion |
| ana_en_o | output | 4 | Analog pin function enables |
| rd_hi_o | output | 4 | Result bits 9:6 |
| rd_mid_o | output | 4 | Result bits 5:2 |
| rd_lo_o | output | 4 | Result bits 1:0 in bits 3:2 |

## Verification
A wrong setup or divider count shows up as `done_o` rising early or late, and the tick count per conversion exposes it within one conversion. A wrong bit index or a wrong keep/clear decision gives a result that differs from the comparator's input level. That error appears on the nibble outputs at the same edge the flag rises. A result register that updates too early shows its changed nibbles in the middle of the next conversion. A missed restart appears as a completion that comes too soon after the second start.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned RES_W = 10;
  localparam int unsigned NIB_W = 4;

  localparam logic [1:0] REG_CHAN = 2'd0;
  localparam logic [1:0] REG_PIN  = 2'd1;
  localparam logic [1:0] REG_CLK  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_STEP  = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_cfg_regs.sv
module sar_cfg_regs #(
  parameter int unsigned DW  = 4,
  parameter int unsigned CKW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [1:0]     sel_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  chan_o,
  output logic [DW-1:0]  pin_o,
  output logic [CKW-1:0] ck_o
);
  import sar_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_o <= '0;
      pin_o  <= '0;
      ck_o   <= '0;
    end else if (we_i) begin
      case (sel_i)
        REG_CHAN: chan_o <= wdata_i;
        REG_PIN:  pin_o  <= wdata_i;
        REG_CLK:  ck_o   <= wdata_i[CKW-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] div_i,
  output logic          stb_o
);
  logic [CW-1:0] cnt_q;

  assign stb_o = run_i && tick_i && (cnt_q == div_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (stb_o)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         start_i,
  input  logic         step_i,
  input  logic         cmp_i,
  output logic         run_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] dac_o,
  output logic [W-1:0] res_o
);
  import sar_pkg::*;
  localparam int unsigned IW = $clog2(W);

  sar_state_e    st_q;
  logic          setup_q;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  sar_q;
  logic [W-1:0]  sar_res;

  always_comb begin
    sar_res = sar_q;
    if (!cmp_i) sar_res[idx_q] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      setup_q <= 1'b0;
      idx_q   <= '0;
      sar_q   <= '0;
      res_o   <= '0;
      done_o  <= 1'b0;
    end else if (start_i) begin
      st_q    <= ST_SETUP;
      setup_q <= 1'b0;
      sar_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      case (st_q)
        ST_SETUP: if (tick_i) begin
          if (setup_q) begin
            st_q         <= ST_STEP;
            idx_q        <= IW'(W-1);
            sar_q        <= '0;
            sar_q[W-1]   <= 1'b1;
          end else begin
            setup_q <= 1'b1;
          end
        end
        ST_STEP: if (step_i) begin
          if (idx_q == '0) begin
            sar_q  <= sar_res;
            res_o  <= sar_res;
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            sar_q          <= sar_res;
            sar_q[idx_q-1] <= 1'b1;
            idx_q          <= idx_q - IW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign run_o  = (st_q == ST_STEP);
  assign busy_o = (st_q != ST_IDLE);
  assign dac_o  = busy_o ? sar_q : '0;
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int unsigned RES_W    = sar_pkg::RES_W,
  parameter int unsigned NIB_W    = sar_pkg::NIB_W,
  parameter int unsigned DIV_BASE = 6,
  parameter int unsigned CK_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inst_tick_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [NIB_W-1:0] cfg_wdata_i,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       ch_sel_o,
  output logic             mode_o,
  output logic [NIB_W-1:0] ana_en_o,
  output logic [NIB_W-1:0] rd_hi_o,
  output logic [NIB_W-1:0] rd_mid_o,
  output logic [NIB_W-1:0] rd_lo_o
);
  localparam int unsigned DIV_MAX = DIV_BASE << 3;
  localparam int unsigned CW      = $clog2(DIV_MAX + 1);

  logic [NIB_W-1:0] chan_q;
  logic [CK_W-1:0]  ck_q;
  logic [CW-1:0]    div_val;
  logic             run, step, start_ok;
  logic [RES_W-1:0] res;

  sar_cfg_regs #(.DW(NIB_W), .CKW(CK_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .sel_i  (cfg_sel_i),
    .wdata_i(cfg_wdata_i),
    .chan_o (chan_q),
    .pin_o  (ana_en_o),
    .ck_o   (ck_q)
  );

  // bit 2 of the code is reserved
  assign div_val  = CW'(DIV_BASE) << ck_q[1:0];
  assign ch_sel_o = chan_q[1:0];
  assign mode_o   = chan_q[3];
  assign start_ok = start_i && !mode_o;

  sar_clk_div #(.CW(CW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_i (inst_tick_i),
    .div_i  (div_val),
    .stb_o  (step)
  );

  sar_core #(.W(RES_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (inst_tick_i),
    .start_i(start_ok),
    .step_i (step),
    .cmp_i  (cmp_i),
    .run_o  (run),
    .busy_o (busy_o),
    .done_o (done_o),
    .dac_o  (dac_code_o),
    .res_o  (res)
  );

  assign rd_hi_o  = res[RES_W-1 -: NIB_W];
  assign rd_mid_o = res[RES_W-NIB_W-1 -: NIB_W];
  assign rd_lo_o  = {res[1:0], {(NIB_W-2){1'b0}}};
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       inst_tick_i,
  input logic       start_i,
  input logic       mode_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [9:0] dac_code_o,
  input logic [3:0] rd_hi_o,
  input logic [3:0] rd_mid_o,
  input logic [3:0] rd_lo_o
);
  AST_START_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !mode_o) |=> (!done_o && busy_o)); // R3
  AST_MODE_BLOCKS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_o && !busy_o) |=> !busy_o); // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R4
  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !inst_tick_i && !start_i) |=> $stable(dac_code_o)); // R4
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({rd_hi_o, rd_mid_o, rd_lo_o}) |-> $rose(done_o)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(start_i && !mode_o)) |=> done_o); // R7
endmodule

bind sar_adc_seq sar_adc_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .inst_tick_i(inst_tick_i),
  .start_i    (start_i),
  .mode_o     (mode_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .dac_code_o (dac_code_o),
  .rd_hi_o    (rd_hi_o),
  .rd_mid_o   (rd_mid_o),
  .rd_lo_o    (rd_lo_o)
);

// File: tb/sim_sar_adc_seq.sv
`timescale 1ns/1ps
module sim_sar_adc_seq;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b1;
  logic       tick_alt = 1'b0;
  logic       we = 1'b0;
  logic [1:0] sel = '0;
  logic [3:0] wd = '0;
  logic       start = 1'b0;
  logic [9:0] vin = '0;
  logic       cmp;
  logic [9:0] dac;
  logic       busy, done, mode;
  logic [1:0] ch;
  logic [3:0] ana, hi, mid, lo;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;
  always @(negedge clk) tick <= tick_alt ? ~tick : 1'b1;
  assign cmp = (vin >= dac);

  sar_adc_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .inst_tick_i(tick),
    .cfg_we_i(we), .cfg_sel_i(sel), .cfg_wdata_i(wd),
    .start_i(start), .cmp_i(cmp), .dac_code_o(dac),
    .busy_o(busy), .done_o(done), .ch_sel_o(ch), .mode_o(mode),
    .ana_en_o(ana), .rd_hi_o(hi), .rd_mid_o(mid), .rd_lo_o(lo)
  );

  // bits 13 tick_alt, 12:10 clock code, 9:0 input level
  localparam logic [13:0] VEC [8] = '{
    {1'b0, 3'd0, 10'h000}, {1'b0, 3'd0, 10'h3FF},
    {1'b0, 3'd0, 10'h200}, {1'b0, 3'd1, 10'h1FF},
    {1'b1, 3'd0, 10'h2AA}, {1'b0, 3'd2, 10'h155},
    {1'b0, 3'd4, 10'h001}, {1'b1, 3'd3, 10'h3FE}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [3:0] d);
    @(negedge clk); we = 1'b1; sel = s; wd = d;
    @(posedge clk); #1; we = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
  endtask

  // counts ticks after the start edge until done rises
  task automatic wait_done(output int n);
    n = 0;
    for (int i = 0; i < 4000; i++) begin
      logic t;
      @(negedge clk); #1; t = tick;
      @(posedge clk); #1;
      if (t) n++;
      if (done) break;
    end
  endtask

  task automatic ticks(input int k);
    int c = 0;
    while (c < k) begin
      logic t;
      @(negedge clk); #1; t = tick;
      @(posedge clk); #1;
      if (t) c++;
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n, exp_n;
    logic [9:0] a;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(!done && !busy && dac == 0, "R1", {done, busy}, 0);
    chk({hi, mid, lo} == 0 && !mode && ch == 0 && ana == 0, "R1", {hi, mid, lo}, 0);
    rst_ni = 1'b1;

    // R2
    wr(2'd0, 4'b1010);
    chk(ch == 2'd2 && mode, "R2", {mode, ch}, 3'b110);
    wr(2'd1, 4'b0001);
    chk(ana == 4'b0001, "R2", ana, 1);
    // R3: start ignored in non-conversion mode
    kick();
    chk(!busy, "R3", busy, 0);
    ticks(10);
    chk(!busy && !done, "R3", {busy, done}, 0);
    wr(2'd0, 4'b0000);
    chk(!mode && ch == 0, "R2", {mode, ch}, 0);

    // R5: setup then MSB trial
    vin = 10'h155;
    kick();
    chk(busy && !done, "R3", {busy, done}, 2'b10);
    chk(dac == 0, "R5", dac, 0);
    ticks(2);
    chk(dac == 10'h200, "R5", dac, 10'h200);
    ticks(6);
    chk(dac == 10'h100, "R5", dac, 10'h100);
    wait_done(n);

    // vector table: R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      logic [13:0] v;
      v = VEC[i];
      tick_alt = v[13];
      wr(2'd2, {1'b0, v[12:10]});
      vin = v[9:0];
      kick();
      wait_done(n);
      exp_n = 2 + 10 * (6 << v[11:10]);
      chk(n == exp_n, "R4", n, exp_n);
      chk(done, "R4", done, 1);
      chk({hi, mid} == vin[9:2], "R6", {hi, mid}, vin[9:2]);
      chk(lo == {vin[1:0], 2'b00}, "R6", lo, {vin[1:0], 2'b00});
      chk({hi, mid, lo[3:2]} == vin, "R5", {hi, mid, lo[3:2]}, vin);
    end
    tick_alt = 1'b0;
    wr(2'd2, 4'd0);

    // R7: hold during next conversion, flag sticky
    a = vin;
    ticks(15);
    chk(done && {hi, mid, lo[3:2]} == a, "R7", {hi, mid, lo[3:2]}, a);
    vin = 10'h0F0;
    kick();
    ticks(30);
    chk({hi, mid, lo[3:2]} == a && !done, "R7", {hi, mid, lo[3:2]}, a);

    // R8: restart mid-conversion
    vin = 10'h33C;
    kick();
    wait_done(n);
    chk(n == 62, "R8", n, 62);
    chk({hi, mid, lo[3:2]} == 10'h33C, "R8", {hi, mid, lo[3:2]}, 10'h33C);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule